// File: doc/BRIEF.md
# Ternary Fixed-Point Settling Engine

This block works out how a small gate network behaves once it is allowed to settle with unknown gate delays. It starts from a binary state and a fixed input. Each signal is carried as a three-valued quantity: logic 0, logic 1, or unknown (X). The engine runs two iterative passes over the network. The network is fixed in the design and is made of three-valued versions of ordinary gates.

The first pass, the widening pass, finds every variable that could be disturbed by a race. At each step it replaces each variable with the least upper bound of its current value and its next value. The least upper bound of two different binary values is X. The pass stops when a step changes nothing.

The second pass, the narrowing pass, starts from the result of the widening pass. At each step it replaces the state with its next value, and it stops when a step changes nothing. Variables that are still X at the end are ones whose final value depends on delays.

A caller loads the input and the start state and pulses `start`. It then waits for the single-cycle `done` pulse, which comes with both result vectors and both step counts. While a pass is running, every state change is also shown on a step-trace port.

Top module: `tsim_engine`

## Requirements
- R1: Each value uses two bits: 00 is 0, 01 is 1 and 11 is X. The code 10 is illegal. When an illegal code is present on `x_in` or `init_st` at start, the engine treats it as X and raises `bad_code` together with `done`.
- R2: The built-in network has next-state functions n0 = x, n1 = s0 OR s1, n2 = NOT s1 and n3 = NAND(s0, s2, s3). Variable i sits at bits [2i+1:2i] of every state vector. Each gate gives X exactly when binary values covered by its inputs could drive its output both ways; with all inputs binary it gives the Boolean result.
- R3: The widening pass repeats s := lub(s, next(s)) and stops at the first step that leaves s unchanged. It reports the final state on `res_a` and the number of state-changing steps on `cnt_a`.
- R4: The narrowing pass starts from `res_a` and repeats t := next(t) until t is unchanged. It reports the final state on `res_b` and the number of state-changing steps on `cnt_b`.
- R5: During the widening pass a variable only changes from binary to X. During the narrowing pass a variable only changes from X to binary.
- R6: `err` is raised with `done` if a pass would need more than 4 (the number of variables) state-changing steps. For the built-in network `err` stays 0.
- R7: A `start` pulse that arrives while `busy` is high has no effect on the run in progress or on its results.
- R8: After reset, `done`, `busy` and `err` are 0. `done` is high for exactly one cycle per run, and at that cycle the results and counts are valid.
- R9: For every state-changing step, `step_vld` is high for one cycle. In that cycle `step_pass` shows the pass (0 for widening, 1 for narrowing) and `step_st` shows the new state.
- R10: With x = 1 and start state s0..s3 = 0,0,1,1, the widening pass ends at all-X after 3 steps. The narrowing pass then goes through 1XXX, 11XX, 110X and 1101 (listed s0 first) and ends with `cnt_b` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run; ignored while busy |
| x_in | input | 2 | Ternary-coded input x |
| init_st | input | 8 | Ternary-coded start state, variable i at [2i+1:2i] |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A run is in progress |
| res_a | output | 8 | Widening-pass fixed point |
| res_b | output | 8 | Narrowing-pass fixed point |
| cnt_a | output | 3 | State-changing steps of the widening pass |
| cnt_b | output | 3 | State-changing steps of the narrowing pass |
| err | output | 1 | A pass exceeded its step bound |
| bad_code | output | 1 | An illegal code was seen at start |
| step_vld | output | 1 | A state-changing step was just committed |
| step_pass | output | 1 | Pass of that step |
| step_st | output | 8 | State after that step |

## Verification
The bench follows the race example step by step. An engine that used plain evaluation in the widening pass would settle to a binary state instead of all-X. An engine that left out the widening pass would report the wrong narrowing sequence. An engine that counted evaluations instead of changes would report counts one too high. The bench also runs a start state that is already stable, where both counts must be zero. It runs an input whose illegal code must be treated as X and flagged on `bad_code`. Finally, it sends a second `start` during a run; a design that accepted it would finish with the wrong results.

// File: rtl/tsim_pkg.sv
package tsim_pkg;
  localparam int NV = 4;
  localparam int NI = 1;
  localparam int SW = 2 * NV;
  localparam int XW = 2 * NI;
  localparam int CW = $clog2(NV + 2);

  typedef logic [1:0] tv_t;
  localparam tv_t T0 = 2'b00;
  localparam tv_t T1 = 2'b01;
  localparam tv_t TX = 2'b11;

  function automatic tv_t t_norm(tv_t a);
    return (a == 2'b10) ? TX : a;
  endfunction

  function automatic tv_t t_not(tv_t a);
    case (a)
      T0:      return T1;
      T1:      return T0;
      default: return TX;
    endcase
  endfunction

  function automatic tv_t t_or2(tv_t a, tv_t b);
    if (a == T1 || b == T1) return T1;
    if (a == T0 && b == T0) return T0;
    return TX;
  endfunction

  function automatic tv_t t_and2(tv_t a, tv_t b);
    if (a == T0 || b == T0) return T0;
    if (a == T1 && b == T1) return T1;
    return TX;
  endfunction

  function automatic tv_t t_lub(tv_t a, tv_t b);
    return (a == b) ? a : TX;
  endfunction

  // every variable of a is below or equal to the one in b
  function automatic logic vec_le(logic [SW-1:0] a, logic [SW-1:0] b);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NV; i++)
      if (!(a[2*i+:2] == b[2*i+:2] || b[2*i+:2] == TX)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic vec_legal(logic [SW-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NV; i++)
      if (a[2*i+:2] == 2'b10) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/tsim_excite.sv
module tsim_excite
  import tsim_pkg::*;
(
  input  logic [XW-1:0] xin,
  input  logic [SW-1:0] st,
  output logic [SW-1:0] exc
);
  tv_t s0, s1, s2, s3, x;

  always_comb begin
    x  = xin[1:0];
    s0 = st[1:0];
    s1 = st[3:2];
    s2 = st[5:4];
    s3 = st[7:6];
    exc[1:0] = x;
    exc[3:2] = t_or2(s0, s1);
    exc[5:4] = t_not(s1);
    exc[7:6] = t_not(t_and2(t_and2(s0, s2), s3));
  end
endmodule

// File: rtl/tsim_merge.sv
module tsim_merge
  import tsim_pkg::*;
(
  input  logic          narrow,
  input  logic [SW-1:0] st,
  input  logic [SW-1:0] exc,
  output logic [SW-1:0] nxt,
  output logic          same
);
  for (genvar i = 0; i < NV; i++) begin : g_var
    assign nxt[2*i+:2] = narrow ? exc[2*i+:2] : t_lub(st[2*i+:2], exc[2*i+:2]);
  end
  assign same = (nxt == st);
endmodule

// File: rtl/tsim_ctrl.sv
module tsim_ctrl
  import tsim_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  input  logic [SW-1:0] init_st,
  input  logic [SW-1:0] nxt,
  input  logic          same,
  output logic          narrow,
  output logic [XW-1:0] xr,
  output logic [SW-1:0] st,
  output logic [SW-1:0] res_a,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic          done,
  output logic          busy,
  output logic          err,
  output logic          bad_code,
  output logic          step_vld,
  output logic          step_pass
);
  typedef enum logic [1:0] {S_IDLE, S_WIDE, S_NARR} ph_t;
  ph_t ph;

  localparam logic [CW-1:0] LIMIT = CW'(NV);

  logic accept, wide_adv, narr_adv, wide_over, narr_over;
  assign accept    = (ph == S_IDLE) && start;
  assign wide_over = (ph == S_WIDE) && !same && (cnt_a == LIMIT);
  assign narr_over = (ph == S_NARR) && !same && (cnt_b == LIMIT);
  assign wide_adv  = (ph == S_WIDE) && !same && !wide_over;
  assign narr_adv  = (ph == S_NARR) && !same && !narr_over;
  assign narrow    = (ph == S_NARR);
  assign busy      = (ph != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; xr <= '0; st <= '0; res_a <= '0;
      cnt_a <= '0; cnt_b <= '0; done <= 1'b0; err <= 1'b0;
      bad_code <= 1'b0; step_vld <= 1'b0; step_pass <= 1'b0;
    end else begin
      done <= 1'b0;
      step_vld <= 1'b0;
      case (ph)
        S_IDLE: if (accept) begin
          for (int i = 0; i < NI; i++) xr[2*i+:2] <= t_norm(x_in[2*i+:2]);
          for (int i = 0; i < NV; i++) st[2*i+:2] <= t_norm(init_st[2*i+:2]);
          bad_code <= !vec_legal(init_st) || (x_in[1:0] == 2'b10);
          cnt_a <= '0; cnt_b <= '0; err <= 1'b0;
          ph <= S_WIDE;
        end
        S_WIDE: begin
          if (same) begin
            res_a <= st; ph <= S_NARR;
          end else if (wide_over) begin
            res_a <= st; err <= 1'b1; done <= 1'b1; ph <= S_IDLE;
          end else begin
            st <= nxt; cnt_a <= cnt_a + 1'b1;
            step_vld <= 1'b1; step_pass <= 1'b0;
          end
        end
        S_NARR: begin
          if (same) begin
            done <= 1'b1; ph <= S_IDLE;
          end else if (narr_over) begin
            err <= 1'b1; done <= 1'b1; ph <= S_IDLE;
          end else begin
            st <= nxt; cnt_b <= cnt_b + 1'b1;
            step_vld <= 1'b1; step_pass <= 1'b1;
          end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  // R5: widening only raises toward X
  a_r5_wide_rises: assert property (@(posedge clk) disable iff (!rst_n)
    wide_adv |=> vec_le($past(st), st));
  // R5: narrowing only lowers toward binary
  a_r5_narr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    narr_adv |=> vec_le(st, $past(st)));
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: start while busy leaves captured input untouched
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xr));
  // R1: the working state never holds the illegal code
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vec_legal(st));
  // R6: step counters stay within the variable count
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a <= LIMIT) && (cnt_b <= LIMIT));
  // R9: a step strobe never coincides with done
  a_r9_step_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    step_vld |-> !done);
endmodule

// File: rtl/tsim_engine.sv
module tsim_engine
  import tsim_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  input  logic [SW-1:0] init_st,
  output logic          done,
  output logic          busy,
  output logic [SW-1:0] res_a,
  output logic [SW-1:0] res_b,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic          err,
  output logic          bad_code,
  output logic          step_vld,
  output logic          step_pass,
  output logic [SW-1:0] step_st
);
  logic [XW-1:0] xr;
  logic [SW-1:0] st, exc, nxt;
  logic          same, narrow;

  tsim_excite u_exc (.xin(xr), .st(st), .exc(exc));

  tsim_merge u_mrg (.narrow(narrow), .st(st), .exc(exc), .nxt(nxt), .same(same));

  tsim_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .init_st(init_st),
    .nxt(nxt), .same(same), .narrow(narrow), .xr(xr), .st(st), .res_a(res_a),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .done(done), .busy(busy), .err(err),
    .bad_code(bad_code), .step_vld(step_vld), .step_pass(step_pass)
  );

  assign res_b   = st;
  assign step_st = st;

  // R8: done never rises while the engine still reports busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/sim_tsim_engine.sv
`timescale 1ns/1ps
module sim_tsim_engine;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] x_in = '0;
  logic [7:0] init_st = '0;
  logic done, busy, err, bad_code, step_vld, step_pass;
  logic [7:0] res_a, res_b, step_st;
  logic [2:0] cnt_a, cnt_b;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tsim_engine u0 (.clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .init_st(init_st), .done(done), .busy(busy), .res_a(res_a), .res_b(res_b),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .err(err), .bad_code(bad_code),
    .step_vld(step_vld), .step_pass(step_pass), .step_st(step_st));

  // step trace recorder
  logic [7:0] aseq [8];
  logic [7:0] bseq [8];
  int an = 0, bn = 0;
  always @(negedge clk) if (step_vld) begin
    if (!step_pass) begin if (an < 8) aseq[an] = step_st; an++; end
    else begin if (bn < 8) bseq[bn] = step_st; bn++; end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model: each value as (may be 0, may be 1)
  function automatic logic m0(logic [1:0] c); return c != 2'b01; endfunction
  function automatic logic m1(logic [1:0] c); return c != 2'b00; endfunction
  function automatic logic [1:0] enc(logic z, logic o);
    return (z && o) ? 2'b11 : (o ? 2'b01 : 2'b00);
  endfunction
  function automatic logic [7:0] m_next(logic [1:0] x, logic [7:0] s);
    logic [1:0] a, b, c, d;
    a = s[1:0]; b = s[3:2]; c = s[5:4]; d = s[7:6];
    m_next[1:0] = enc(m0(x), m1(x));
    m_next[3:2] = enc(m0(a) & m0(b), m1(a) | m1(b));
    m_next[5:4] = enc(m1(b), m0(b));
    m_next[7:6] = enc(m1(a) & m1(c) & m1(d), m0(a) | m0(c) | m0(d));
  endfunction
  function automatic logic [7:0] m_join(logic [7:0] p, logic [7:0] q);
    for (int i = 0; i < 4; i++)
      m_join[2*i+:2] = enc(m0(p[2*i+:2]) | m0(q[2*i+:2]), m1(p[2*i+:2]) | m1(q[2*i+:2]));
  endfunction

  task automatic model(input logic [1:0] x, input logic [7:0] s0,
                       output logic [7:0] ra, output logic [7:0] rb,
                       output int ca, output int cb);
    logic [7:0] s, n;
    s = m_join(s0, s0); ca = 0; cb = 0;
    for (int k = 0; k < 8; k++) begin
      n = m_join(s, m_next(x, s));
      if (n == s) break;
      s = n; ca++;
    end
    ra = s;
    for (int k = 0; k < 8; k++) begin
      n = m_next(x, s);
      if (n == s) break;
      s = n; cb++;
    end
    rb = s;
  endtask

  task automatic pulse_start(input logic [1:0] x, input logic [7:0] s);
    @(negedge clk); x_in = x; init_st = s; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_case(string name, input logic [1:0] x, input logic [7:0] s, input bit bad);
    logic [7:0] ra, rb; int ca, cb; bit ok;
    model(x, s, ra, rb, ca, cb);
    an = 0; bn = 0;
    pulse_start(x, s);
    wait_done(ok);
    check({name, " R8 done seen"}, ok, 1);
    check({name, " R3 res_a"}, res_a, ra);
    check({name, " R3 cnt_a"}, cnt_a, ca);
    check({name, " R4 res_b"}, res_b, rb);
    check({name, " R4 cnt_b"}, cnt_b, cb);
    check({name, " R6 err"}, err, 0);
    check({name, " R1 bad_code"}, bad_code, bad);
    check({name, " R9 step counts"}, an + bn, ca + cb);
    @(negedge clk);
    check({name, " R8 done one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 reset done", done, 0);
    check("R8 reset busy", busy, 0);
    check("R8 reset err", err, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_example;
    // x=1; s0..s3 = 0,0,1,1
    run_case("race", 2'b01, 8'b01010000, 0);
    check("R10 widening all X", res_a, 8'hFF);
    check("R10 widening steps", cnt_a, 3);
    check("R5 wide step1", aseq[0], 8'b01010011);
    check("R5 wide step2", aseq[1], 8'b11011111);
    check("R10 narrow 1XXX", bseq[0], 8'b11111101);
    check("R10 narrow 11XX", bseq[1], 8'b11110101);
    check("R10 narrow 110X", bseq[2], 8'b11000101);
    check("R10 narrow 1101", bseq[3], 8'b01000101);
    check("R10 narrow steps", cnt_b, 4);
  endtask

  task automatic t_stable;
    run_case("stable", 2'b01, 8'b01000101, 0);
    check("R2 stable counts", {cnt_a, cnt_b}, 0);
    check("R2 stable binary result", res_b, 8'b01000101);
  endtask

  task automatic t_zero;
    run_case("zero", 2'b00, 8'b00000000, 0);
    check("R2 binary settle 0011", res_b, 8'b01010000);
  endtask

  task automatic t_illegal;
    run_case("illegal_x", 2'b10, 8'b00000000, 1);
    run_case("illegal_s", 2'b01, 8'b00000010, 1);
    run_case("unknown_x", 2'b11, 8'b01000101, 0);
  endtask

  task automatic t_busy_start;
    bit ok;
    an = 0; bn = 0;
    pulse_start(2'b01, 8'b01010000);
    @(negedge clk);
    check("R7 busy during run", busy, 1);
    x_in = 2'b00; init_st = 8'b00000000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(ok);
    check("R7 run completed", ok, 1);
    check("R7 res_a unaffected", res_a, 8'hFF);
    check("R7 res_b unaffected", res_b, 8'b01000101);
    check("R7 cnt_b unaffected", cnt_b, 4);
    @(negedge clk);
    check("R7 idle after run", busy, 0);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    repeat (2) @(negedge clk);
    t_example;
    t_stable;
    t_zero;
    t_illegal;
    t_busy_start;
    t_example;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule